// File: doc/BRIEF.md
# Packed Two-Entry Colour Lookup Table

This block is the colour lookup table of a display controller. A register bus writes and reads 128 words of 32 bits each. Each word carries two 16-bit colour entries, so the table holds 256 logical entries. Software reads back exactly the word it wrote, because the table keeps the raw words and never a converted form.

A separate lookup port takes an 8-bit pixel index and returns 8-bit red, green and blue values one clock later. The index selects a word and one half of it. The three 5-bit channel fields in that half are widened to 8 bits, and the top bit of the entry plays no part. A swap input exchanges red and blue for panels that are wired in blue-first order. Gamma correction, dithering and the pixel fetch engine sit outside this block.

Top module: `pal_pack_lut`

## Requirements
- R1: A bus write whose byte address lies in 0x200..0x3FF stores the 32-bit data in word (address - 0x200) / 4. A bus read of that address returns the stored word, all 32 bits unchanged, on `bus_rd_data` one cycle after `bus_rd_en`.
- R2: Address bits 1:0 play no part in selecting a word. A write outside 0x200..0x3FF changes no word. A read outside that range returns zero one cycle later.
- R3: Lookup index n reads word n/2 (index bits 7:1). An even n uses bits 15:0 of that word and an odd n uses bits 31:16.
- R4: Within the selected 16-bit entry, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Each output channel equals its 5-bit field shifted left by three, so output bits 2:0 are zero.
- R5: Bit 15 of an entry has no effect on any colour output.
- R6: `col_valid` is high exactly one cycle after `pix_valid` was high. The colour outputs carry the result in that same cycle.
- R7: When `swap_rb` is high in the cycle the index is presented, the red output carries the blue field and the blue output carries the red field. Green is unchanged.
- R8: If a lookup and a bus write touch the same word in the same cycle, the lookup returns the word as it was before the write. A later lookup returns the new data.
- R9: Reset clears every word to zero and drives `col_valid` and `bus_rd_data` low.
- R10: `bus_rd_data` holds its value in any cycle that follows a cycle without `bus_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_we | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rd_data | output | 32 | Bus read data, registered |
| pix_valid | input | 1 | Lookup request |
| pix_idx | input | 8 | Lookup entry index |
| swap_rb | input | 1 | Exchange red and blue for this lookup |
| col_valid | output | 1 | Lookup result valid |
| col_r | output | 8 | Red output |
| col_g | output | 8 | Green output |
| col_b | output | 8 | Blue output |

## Verification
The hardest case to reach is a bus write and a lookup that land on the same word in the same clock. Ordinary software-like traffic never lines them up. The bench drives both strobes on one falling edge, with the write address and the pixel index chosen to name one word. It then checks that the old colour comes out first and the new colour comes out on the following lookup. The intensity bit is proven inert in a second way: all 256 entries are rewritten with only their bit-15 values flipped, and each lookup must return the same colour as before.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int ENT_W = 16;
  localparam int CH_W  = 5;
  localparam int OUT_W = 8;

  typedef struct packed {
    logic [OUT_W-1:0] r;
    logic [OUT_W-1:0] g;
    logic [OUT_W-1:0] b;
  } rgb_t;

  // widen a channel field by appending zero bits
  function automatic logic [OUT_W-1:0] widen(input logic [CH_W-1:0] f);
    return {f, {(OUT_W-CH_W){1'b0}}};
  endfunction

  // decode one packed entry; the top bit is never consulted
  function automatic rgb_t decode_entry(input logic [ENT_W-1:0] ent, input logic swap);
    rgb_t c;
    logic [OUT_W-1:0] lo_ch, hi_ch;
    lo_ch = widen(ent[CH_W-1:0]);
    hi_ch = widen(ent[3*CH_W-1:2*CH_W]);
    c.g   = widen(ent[2*CH_W-1:CH_W]);
    c.r   = swap ? hi_ch : lo_ch;
    c.b   = swap ? lo_ch : hi_ch;
    return c;
  endfunction
endpackage

// File: rtl/pal_addr_dec.sv
module pal_addr_dec #(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int WORDS  = 128
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic                     hit,
  output logic [$clog2(WORDS)-1:0] word
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int SPAN  = WORDS * 4;
  localparam logic [ADDR_W:0] LO = BASE;
  localparam logic [ADDR_W:0] HI = BASE + SPAN;

  logic [ADDR_W:0] ext;
  logic [ADDR_W:0] off;

  always_comb begin
    ext  = {1'b0, addr};
    off  = ext - LO;
    hit  = (ext >= LO) && (ext < HI);
    word = off[IDX_W+1:2];
  end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int WORDS = 128,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] wa,
  input  logic [DW-1:0]            wd,
  input  logic                     bus_re,
  input  logic                     bus_hit,
  input  logic [$clog2(WORDS)-1:0] bus_ra,
  output logic [DW-1:0]            bus_rd,
  input  logic                     lut_re,
  input  logic [$clog2(WORDS)-1:0] lut_ra,
  output logic [DW-1:0]            lut_rd
);
  logic [DW-1:0] mem [WORDS];

  // reads sample the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      bus_rd <= '0;
      lut_rd <= '0;
    end else begin
      if (we) mem[wa] <= wd;
      if (bus_re) bus_rd <= bus_hit ? mem[bus_ra] : '0;
      if (lut_re) lut_rd <= mem[lut_ra];
    end
  end
endmodule

// File: rtl/pal_expand.sv
module pal_expand
  import pal_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word,
  input  logic          upper,
  input  logic          swap,
  output rgb_t          color
);
  logic [ENT_W-1:0] ent;

  always_comb begin
    ent   = upper ? word[2*ENT_W-1:ENT_W] : word[ENT_W-1:0];
    color = decode_entry(ent, swap);
  end
endmodule

// File: rtl/pal_pack_lut.sv
module pal_pack_lut
  import pal_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int WORDS  = 128,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rd_data,
  input  logic              pix_valid,
  input  logic [7:0]        pix_idx,
  input  logic              swap_rb,
  output logic              col_valid,
  output logic [7:0]        col_r,
  output logic [7:0]        col_g,
  output logic [7:0]        col_b
);
  localparam int IDX_W = $clog2(WORDS);

  logic             rd_hit;
  logic [IDX_W-1:0] bus_word;
  logic             wr_hit;
  logic [IDX_W-1:0] lut_word;
  logic [DW-1:0]    lut_q;
  logic             upper_q;
  logic             swap_q;
  logic             vld_q;
  rgb_t             color;

  pal_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) i_dec (
    .addr (bus_addr),
    .hit  (rd_hit),
    .word (bus_word)
  );

  assign wr_hit   = bus_we && rd_hit;
  assign lut_word = pix_idx[IDX_W:1];

  pal_store #(.WORDS(WORDS), .DW(DW)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_hit),
    .wa      (bus_word),
    .wd      (bus_wdata),
    .bus_re  (bus_rd_en),
    .bus_hit (rd_hit),
    .bus_ra  (bus_word),
    .bus_rd  (bus_rd_data),
    .lut_re  (pix_valid),
    .lut_ra  (lut_word),
    .lut_rd  (lut_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      upper_q <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      vld_q <= pix_valid;
      if (pix_valid) begin
        upper_q <= pix_idx[0];
        swap_q  <= swap_rb;
      end
    end
  end

  pal_expand #(.DW(DW)) i_exp (
    .word  (lut_q),
    .upper (upper_q),
    .swap  (swap_q),
    .color (color)
  );

  assign col_valid = vld_q;
  assign col_r     = color.r;
  assign col_g     = color.g;
  assign col_b     = color.b;
endmodule

// File: rtl/pal_pack_chk.sv
module pal_pack_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd_en,
  input logic          rd_hit,
  input logic [DW-1:0] bus_rd_data,
  input logic          pix_valid,
  input logic          col_valid,
  input logic [7:0]    col_r,
  input logic [7:0]    col_g,
  input logic [7:0]    col_b
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> col_valid); // R6
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !col_valid); // R6
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> (col_r[2:0] == 3'd0 && col_g[2:0] == 3'd0 && col_b[2:0] == 3'd0)); // R4
  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !rd_hit) |=> (bus_rd_data == '0)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rd_data)); // R10
endmodule

bind pal_pack_lut pal_pack_chk #(.DW(DW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd_en   (bus_rd_en),
  .rd_hit      (rd_hit),
  .bus_rd_data (bus_rd_data),
  .pix_valid   (pix_valid),
  .col_valid   (col_valid),
  .col_r       (col_r),
  .col_g       (col_g),
  .col_b       (col_b)
);

// File: tb/test_pal_pack_lut.sv
module test_pal_pack_lut;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0, bus_rd_en = 0, pix_valid = 0, swap_rb = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  pix_idx = '0;
  logic [31:0] bus_rd_data;
  logic        col_valid;
  logic [7:0]  col_r, col_g, col_b;

  int tests = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  pal_pack_lut i_pal_pack_lut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd_data(bus_rd_data),
    .pix_valid(pix_valid), .pix_idx(pix_idx), .swap_rb(swap_rb),
    .col_valid(col_valid), .col_r(col_r), .col_g(col_g), .col_b(col_b)
  );

  function automatic logic [31:0] pat(input int w, input logic [31:0] seed);
    return (w * 32'h9E3779B1) ^ seed;
  endfunction

  // expected colour packed as {valid, r, g, b}
  function automatic logic [24:0] expect_col(input logic [31:0] w, input int idx, input bit sw);
    int e, r, g, b;
    e = (idx % 2 == 1) ? int'(w / 65536) : int'(w % 65536);
    r = (e % 32) * 8;
    g = ((e / 32) % 32) * 8;
    b = ((e / 1024) % 32) * 8;
    if (sw) return {1'b1, 8'(b), 8'(g), 8'(r)};
    return {1'b1, 8'(r), 8'(g), 8'(b)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd_en = 1; bus_addr = a;
    @(negedge clk); d = bus_rd_data; bus_rd_en = 0;
  endtask

  task automatic lookup(input int idx, input bit sw, output logic [24:0] c);
    @(negedge clk); pix_valid = 1; pix_idx = 8'(idx); swap_rb = sw;
    @(negedge clk); c = {col_valid, col_r, col_g, col_b}; pix_valid = 0; swap_rb = 0;
  endtask

  logic [31:0] shadow [128];
  logic [31:0] rd;
  logic [24:0] c;

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 col_valid in reset", 32'(col_valid), 0);
    check("R9 rd_data in reset", bus_rd_data, 0);
    rst_n = 1;
    lookup(37, 0, c);
    check("R9 cleared entry", 32'(c), 32'({1'b1, 24'h0}));
    bus_read(12'h20C, rd);
    check("R9 cleared word", rd, 0);
    @(negedge clk);
    check("R6 valid drops", 32'(col_valid), 0);

    // R1 fill and read back every word
    for (int w = 0; w < 128; w++) begin
      shadow[w] = pat(w, 32'h5A5A0F0F);
      bus_write(12'(32'h200 + w * 4), shadow[w]);
    end
    for (int w = 0; w < 128; w++) begin
      bus_read(12'(32'h200 + w * 4), rd);
      check("R1 readback", rd, shadow[w]);
    end
    // R10 hold after idle
    @(negedge clk); @(negedge clk);
    check("R10 hold", bus_rd_data, shadow[127]);

    // R3 R4 R6 R7 every entry, both orders
    for (int sw = 0; sw < 2; sw++)
      for (int i = 0; i < 256; i++) begin
        lookup(i, sw[0], c);
        check(sw ? "R7 swapped lookup" : "R3 R4 lookup", 32'(c), 32'(expect_col(shadow[i/2], i, sw[0])));
      end

    // R5 flip only intensity bits, colours must not move
    for (int w = 0; w < 128; w++) begin
      shadow[w] = shadow[w] ^ 32'h80008000;
      bus_write(12'(32'h200 + w * 4), shadow[w]);
    end
    for (int i = 0; i < 256; i++) begin
      lookup(i, 0, c);
      check("R5 intensity ignored", 32'(c), 32'(expect_col(shadow[i/2] ^ 32'h80008000, i, 0)));
    end

    // R2 out-of-window accesses and low address bits
    bus_write(12'h1FC, 32'hDEADBEEF);
    bus_write(12'h400, 32'hCAFEF00D);
    bus_write(12'hFFC, 32'h12345678);
    bus_read(12'h1FC, rd); check("R2 low miss reads zero", rd, 0);
    bus_read(12'h400, rd); check("R2 high miss reads zero", rd, 0);
    for (int w = 0; w < 128; w++) begin
      bus_read(12'(32'h200 + w * 4), rd);
      check("R2 miss write ignored", rd, shadow[w]);
    end
    shadow[9] = 32'h7FFF0421;
    bus_write(12'(32'h200 + 9 * 4 + 2), shadow[9]);
    bus_read(12'(32'h200 + 9 * 4 + 3), rd);
    check("R2 low bits ignored", rd, shadow[9]);
    bus_read(12'(32'h200 + 8 * 4), rd);
    check("R2 neighbour untouched", rd, shadow[8]);

    // R8 collision of write and lookup on word 5
    @(negedge clk);
    bus_we = 1; bus_addr = 12'(32'h200 + 5 * 4); bus_wdata = 32'h1234ABCD;
    pix_valid = 1; pix_idx = 8'd11; swap_rb = 0;
    @(negedge clk);
    c = {col_valid, col_r, col_g, col_b};
    bus_we = 0; pix_valid = 0;
    check("R8 old data on collision", 32'(c), 32'(expect_col(shadow[5], 11, 0)));
    shadow[5] = 32'h1234ABCD;
    lookup(11, 0, c);
    check("R8 new data after", 32'(c), 32'(expect_col(shadow[5], 11, 0)));
    lookup(10, 1, c);
    check("R8 R7 even half new", 32'(c), 32'(expect_col(shadow[5], 10, 1)));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule